// File: doc/BRIEF.md
# Control-Word Driven Datapath

This block is a single-cycle datapath. One 16-bit control word, applied for one clock cycle, chooses two source registers and an optional external constant. It also chooses an operation in the function unit, whether the function result or external data returns to the register file, and whether a write takes place. The register file holds eight registers of `W` bits. It has two combinational read ports and one write port that stores on the rising edge.

The first operand bus drives the address output and the second operand bus drives the data output. A cycle with the write bit clear can therefore present an address and a data value for an external write without changing any register. Two more cycle types use the external data input: one sends that input to a register, and the other uses it in place of the function result.

The block executes one control word on every clock, so it has no handshake. Every port is a plain control or status pin and no back-pressure exists. The sequencer that produces the control words is responsible for their timing.

Top module: `cw_datapath`

## Requirements
- R1: The control word fields are: destination address in bits 15:13, first-source address in bits 12:10, second-source address in bits 9:7, constant select in bit 6, function code in bits 5:2, data-in select in bit 1 and write enable in bit 0.
- R2: Each 3-bit address field selects register Rk directly from its binary value, so 000 selects R0 and 111 selects R7.
- R3: When the constant select is 0, the second operand bus carries the register named by the second-source field. When it is 1, the bus carries `const_in`.
- R4: When the data-in select is 0, the write bus carries the function result. When it is 1, the write bus carries `data_in`.
- R5: When the write enable is 1, the destination register loads the write bus on the rising clock edge. When it is 0, no register changes.
- R6: `addr_out` always equals the first operand bus and `data_out` always equals the second operand bus.
- R7: Function codes 0000 to 0111 are arithmetic, with A as the first operand and B as the second. The codes give, in order: A, A+1, A+B, A+B+1, A+~B, A+~B+1, A-1, A. All results wrap modulo 2^W.
- R8: Function codes 1000, 1001, 1010 and 1011 give A AND B, A OR B, A XOR B and NOT A.
- R9: Function codes 1100, 1101 and 1110 give B, B shifted right by one and B shifted left by one, with a zero shifted into the vacated bit. Code 1111 gives B.
- R10: `flag_n` is the top bit of the function result and `flag_z` is 1 exactly when the result is zero. For arithmetic codes, `flag_c` is the adder carry out and `flag_v` is two's-complement overflow. For every other code, `flag_c` and `flag_v` are 0. The flags always describe the current control word, even when the function result is not written.
- R11: A synchronous active-high `rst` clears all eight registers to zero and blocks any write in that cycle.
- R12: A value written in one cycle can be read on either operand bus in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_word | input | 16 | Control word for the current cycle |
| const_in | input | W | Constant that can be placed on the second operand bus |
| data_in | input | W | External data that can be placed on the write bus |
| addr_out | output | W | First operand bus |
| data_out | output | W | Second operand bus |
| flag_v | output | 1 | Signed overflow of the current arithmetic operation |
| flag_c | output | 1 | Carry out of the current arithmetic operation |
| flag_n | output | 1 | Top bit of the current function result |
| flag_z | output | 1 | Current function result is zero |

## Verification
The bound checker tests several properties on every cycle. When the constant is selected, the second bus must follow the constant, and it must mirror the first bus when both read the same register. A register read must hold steady across a cycle with no write. A register written from `data_in`, or from a zero or negative function result, must read back correctly on the next cycle. Registers must read zero after reset, and the carry and overflow flags must be clear for codes outside arithmetic. Only the bench's reference model can confirm the exact result of each of the sixteen function codes over edge-case operand pairs such as sign-boundary and all-ones values. The same model is needed to confirm the exact flag values for those pairs and the results of long sequences of mixed control words.

// File: rtl/cwdp_pkg.sv
package cwdp_pkg;
  localparam int CW_BITS   = 16;
  localparam int REG_COUNT = 8;
  localparam int RADDR_W   = $clog2(REG_COUNT);
  localparam int FSEL_W    = 4;

  typedef struct packed {
    logic [RADDR_W-1:0] dst;
    logic [RADDR_W-1:0] sela;
    logic [RADDR_W-1:0] selb;
    logic               use_const;
    logic [FSEL_W-1:0]  fsel;
    logic               use_ext;
    logic               wr_en;
  } ctrl_t;

  localparam logic [1:0] GRP_LOGIC = 2'b10;
  localparam logic [1:0] GRP_SHIFT = 2'b11;
endpackage

// File: rtl/cwdp_regfile.sv
module cwdp_regfile #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);
  logic [DEPTH-1:0][W-1:0] store;
  logic [DEPTH-1:0]        wsel;

  for (genvar i = 0; i < DEPTH; i++) begin : g_dec
    assign wsel[i] = we && (waddr == AW'(i));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (rst)          store[i] <= '0;
      else if (wsel[i]) store[i] <= wdata;
    end
  end

  assign rdata_a = store[raddr_a];
  assign rdata_b = store[raddr_b];
endmodule

// File: rtl/cwdp_shifter.sv
module cwdp_shifter #(
  parameter int W = 8
) (
  input  logic [W-1:0] din,
  input  logic [1:0]   mode,
  output logic [W-1:0] dout
);
  always_comb begin
    case (mode)
      2'b01:   dout = {1'b0, din[W-1:1]};
      2'b10:   dout = {din[W-2:0], 1'b0};
      default: dout = din;
    endcase
  end
endmodule

// File: rtl/cwdp_func_unit.sv
module cwdp_func_unit
  import cwdp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      b,
  input  logic [FSEL_W-1:0] fsel,
  output logic [W-1:0]      f,
  output logic              v,
  output logic              c,
  output logic              n,
  output logic              z
);
  logic [W-1:0] y_opnd;
  logic [W:0]   sum;
  logic [W-1:0] logic_res;
  logic [W-1:0] shift_res;
  logic         is_arith;

  always_comb begin
    case (fsel[2:1])
      2'b00:   y_opnd = '0;
      2'b01:   y_opnd = b;
      2'b10:   y_opnd = ~b;
      default: y_opnd = '1;
    endcase
  end

  assign sum = {1'b0, a} + {1'b0, y_opnd} + {{W{1'b0}}, fsel[0]};

  always_comb begin
    case (fsel[1:0])
      2'b00:   logic_res = a & b;
      2'b01:   logic_res = a | b;
      2'b10:   logic_res = a ^ b;
      default: logic_res = ~a;
    endcase
  end

  cwdp_shifter #(.W(W)) u_shift (
    .din  (b),
    .mode (fsel[1:0]),
    .dout (shift_res)
  );

  assign is_arith = ~fsel[3];

  always_comb begin
    case (fsel[3:2])
      GRP_SHIFT: f = shift_res;
      GRP_LOGIC: f = logic_res;
      default:   f = sum[W-1:0];
    endcase
  end

  assign c = is_arith & sum[W];
  assign v = is_arith & (a[W-1] == y_opnd[W-1]) & (sum[W-1] != a[W-1]);
  assign n = f[W-1];
  assign z = (f == '0);
endmodule

// File: rtl/cw_datapath.sv
module cw_datapath
  import cwdp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CW_BITS-1:0] ctrl_word,
  input  logic [W-1:0]       const_in,
  input  logic [W-1:0]       data_in,
  output logic [W-1:0]       addr_out,
  output logic [W-1:0]       data_out,
  output logic               flag_v,
  output logic               flag_c,
  output logic               flag_n,
  output logic               flag_z
);
  ctrl_t        cw;
  logic [W-1:0] rd_a, rd_b, bus_a, bus_b, bus_d, fu_out;

  assign cw = ctrl_t'(ctrl_word);

  cwdp_regfile #(.W(W), .DEPTH(REG_COUNT)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (cw.wr_en),
    .waddr   (cw.dst),
    .wdata   (bus_d),
    .raddr_a (cw.sela),
    .raddr_b (cw.selb),
    .rdata_a (rd_a),
    .rdata_b (rd_b)
  );

  assign bus_a = rd_a;
  assign bus_b = cw.use_const ? const_in : rd_b;

  cwdp_func_unit #(.W(W)) u_fu (
    .a    (bus_a),
    .b    (bus_b),
    .fsel (cw.fsel),
    .f    (fu_out),
    .v    (flag_v),
    .c    (flag_c),
    .n    (flag_n),
    .z    (flag_z)
  );

  assign bus_d    = cw.use_ext ? data_in : fu_out;
  assign addr_out = bus_a;
  assign data_out = bus_b;
endmodule

// File: rtl/cwdp_checker.sv
module cwdp_checker
  import cwdp_pkg::*;
#(
  parameter int W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [CW_BITS-1:0] ctrl_word,
  input logic [W-1:0]       const_in,
  input logic [W-1:0]       data_in,
  input logic [W-1:0]       addr_out,
  input logic [W-1:0]       data_out,
  input logic               flag_v,
  input logic               flag_c,
  input logic               flag_n,
  input logic               flag_z
);
  ctrl_t cw;
  assign cw = ctrl_t'(ctrl_word);

  // R3: a selected constant appears on the second bus
  p_const_mux_r3: assert property (@(posedge clk) disable iff (rst)
    cw.use_const |-> data_out == const_in);

  // R6: both buses reading the same register show the same value
  p_bus_mirror_r6: assert property (@(posedge clk) disable iff (rst)
    (!cw.use_const && cw.selb == cw.sela) |-> data_out == addr_out);

  // R4, R12: external data written last cycle reads back now
  p_ext_write_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(cw.wr_en && cw.use_ext) && cw.sela == $past(cw.dst))
    |-> addr_out == $past(data_in));

  // R5: no write means a repeated read is unchanged
  p_hold_no_write_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!cw.wr_en) && cw.sela == $past(cw.sela))
    |-> addr_out == $past(addr_out));

  // R10: a zero result stored from the function unit reads as zero
  p_zero_result_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(cw.wr_en && !cw.use_ext && flag_z) && cw.sela == $past(cw.dst))
    |-> addr_out == '0);

  // R10: a negative result stored from the function unit keeps its top bit
  p_neg_result_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(cw.wr_en && !cw.use_ext && flag_n) && cw.sela == $past(cw.dst))
    |-> addr_out[W-1]);

  // R10: carry and overflow are clear outside arithmetic codes
  p_flags_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    cw.fsel[3] |-> (!flag_c && !flag_v));

  // R11: every register reads zero right after reset
  p_reset_clear_r11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> addr_out == '0);
endmodule

bind cw_datapath cwdp_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ctrl_word (ctrl_word),
  .const_in  (const_in),
  .data_in   (data_in),
  .addr_out  (addr_out),
  .data_out  (data_out),
  .flag_v    (flag_v),
  .flag_c    (flag_c),
  .flag_n    (flag_n),
  .flag_z    (flag_z)
);

// File: tb/sim_cw_datapath.sv
`timescale 1ns/1ps
module sim_cw_datapath;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [15:0]  ctrl = 16'h0000;
  logic [W-1:0] kin = '0;
  logic [W-1:0] din = '0;
  logic [W-1:0] addr_out, data_out;
  logic         flag_v, flag_c, flag_n, flag_z;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  int mreg[8];

  always #2.5 clk = ~clk;

  cw_datapath #(.W(W)) u0 (
    .clk(clk), .rst(rst), .ctrl_word(ctrl), .const_in(kin), .data_in(din),
    .addr_out(addr_out), .data_out(data_out),
    .flag_v(flag_v), .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z)
  );

  // R1: field packing dst|srcA|srcB|const|func|ext|write from bit 15 down
  function automatic logic [15:0] mk(input int d, input int a, input int b,
                                     input int mb, input int fs, input int md, input int rw);
    logic [15:0] w;
    w = 16'((d % 8) * 8192 + (a % 8) * 1024 + (b % 8) * 128 + (mb % 2) * 64
            + (fs % 16) * 4 + (md % 2) * 2 + (rw % 2));
    return w;
  endfunction

  function automatic int sgn(input int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  // returns result in [7:0], flags {v,c,n,z} in [11:8]
  function automatic int model_fu(input int a, input int b, input int fs);
    int y, ci, r, s, f, v, c;
    v = 0; c = 0; f = 0;
    if (fs < 8) begin
      case (fs / 2)
        0: y = 0;
        1: y = b;
        2: y = 255 - b;
        default: y = 255;
      endcase
      ci = fs % 2;
      r = a + y + ci;
      f = r % 256;
      c = (r > 255) ? 1 : 0;
      s = sgn(a) + sgn(y) + ci;
      v = (s > 127 || s < -128) ? 1 : 0;
    end else begin
      case (fs)
        8:  f = a & b;
        9:  f = a | b;
        10: f = a ^ b;
        11: f = 255 - a;
        13: f = b / 2;
        14: f = (b * 2) % 256;
        default: f = b;
      endcase
    end
    return f + 256 * (v * 8 + c * 4 + ((f >= 128) ? 2 : 0) + ((f == 0) ? 1 : 0));
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one control word at negedge, compare combinational outputs, then step the model
  task automatic apply(input logic [15:0] cw, input int k, input int d, input string tag);
    int aa, ba, dst, fs, bval, res;
    ctrl = cw; kin = W'(k); din = W'(d);
    #1;
    dst = int'(cw[15:13]); aa = int'(cw[12:10]); ba = int'(cw[9:7]); fs = int'(cw[5:2]);
    bval = cw[6] ? k : mreg[ba];
    res = model_fu(mreg[aa], bval, fs);
    chk({tag, " R6 addr_out"}, int'(addr_out), mreg[aa]);
    chk({tag, " R3 data_out"}, int'(data_out), bval);
    chk({tag, " R10 flags"}, int'({flag_v, flag_c, flag_n, flag_z}), res / 256);
    @(posedge clk);
    if (cw[0]) mreg[dst] = cw[1] ? d : res % 256;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    ctrl = mk(0, 0, 0, 0, 1, 1, 1);
    din = 8'hee;
    @(posedge clk);
    for (int i = 0; i < 8; i++) mreg[i] = 0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    int pa[6] = '{0, 255, 127, 128, 8'h5a, 8'h80};
    int pb[6] = '{0, 1, 1, 128, 8'ha5, 8'h7f};
    for (int i = 0; i < 8; i++) mreg[i] = 0;
    @(negedge clk);
    do_reset();
    // R11: all registers zero after reset
    for (int i = 0; i < 8; i++) apply(mk(0, i, 7 - i, 0, 0, 0, 0), 0, 0, "R11 after reset");
    // R4, R2: load each register from data_in, then read each back by address
    for (int i = 0; i < 8; i++) apply(mk(i, 0, 0, 0, 0, 1, 1), 0, 16 * i + 3, "R4 load");
    for (int i = 0; i < 8; i++) apply(mk(0, i, i, 0, 12, 0, 0), 0, 0, "R2 addressing");
    // R7: R1 <= R2 + ~R3 + 1 ; R9: R4 <= R6 << 1 ; R8: R5 <= R0 ^ R0
    apply(mk(1, 2, 3, 0, 5, 0, 1), 0, 0, "R7 subtract");
    apply(mk(4, 0, 6, 0, 14, 0, 1), 0, 0, "R9 shift left");
    apply(mk(5, 0, 0, 0, 10, 0, 1), 0, 0, "R8 xor clear");
    // R12: results visible in the next cycle
    apply(mk(0, 1, 4, 0, 0, 0, 0), 0, 0, "R12 readback");
    apply(mk(0, 5, 5, 0, 0, 0, 0), 0, 0, "R12 readback");
    // R5: write disabled leaves R2 untouched
    apply(mk(2, 3, 3, 0, 2, 1, 0), 0, 8'h99, "R5 no write");
    apply(mk(0, 2, 2, 0, 0, 0, 0), 0, 0, "R5 readback");
    // R7, R8, R9, R10: every function code over edge operand pairs
    for (int p = 0; p < 6; p++) begin
      apply(mk(6, 0, 0, 0, 0, 1, 1), 0, pa[p], "R4 load A");
      apply(mk(7, 0, 0, 0, 0, 1, 1), 0, pb[p], "R4 load B");
      for (int fs = 0; fs < 16; fs++) begin
        apply(mk(3, 6, 7, p % 2, fs, 0, 1), pb[5 - p],
              0, (fs < 8) ? "R7 arith" : (fs < 12) ? "R8 logic" : "R9 shift");
        apply(mk(0, 3, 3, 0, 0, 0, 0), 0, 0, "R12 result");
      end
    end
    // R1: mixed random control words
    for (int i = 0; i < 400; i++) apply(16'($urandom), int'($urandom % 256), int'($urandom % 256), "R1 random");
    // R11: reset mid-run clears everything
    do_reset();
    for (int i = 0; i < 8; i++) apply(mk(0, i, i, 0, 13, 0, 0), 0, 0, "R11 mid reset");
    finish_run();
  end

  initial begin
    #(100000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end
endmodule